// File: doc/BRIEF.md
# Boot Table Section Loader

The loader takes a boot image as a stream of 32-bit words and copies each section of that image into memory. A section starts with two header words: the byte count, then the destination byte address. The payload words follow. The loader turns each payload word into one write on a simple memory port. A header whose byte count is zero closes the table. The loader then stops taking words, and it reports completion together with the address where execution should begin.

Two table layouts are supported, and `mode_i` selects between them.

- **Explicit-entry layout (`mode_i` = 0):** one leading word carries the entry address, and the first section header follows it.
- **Header-only layout (`mode_i` = 1):** there is no leading word. The entry address is the destination address of the last section whose byte count was not zero.

A destination address that is not word-aligned aborts the load and raises an error. The completion and error indications both stay up until the consumer acknowledges them. After the acknowledge, the loader is ready for a new table.

Top module: `sect_loader`

## Requirements
- R1: Each section is a byte-count word followed by a destination-address word. Payload word k of a section is written to byte address dest + 4*k, with the payloads of all sections written in stream order.
- R2: With `mode_i` = 0, the first word of a table is the entry address, and `entry_o` shows that word when `done_o` is high.
- R3: With `mode_i` = 1, `entry_o` at completion equals the destination address of the last section with a nonzero byte count, or 0 if the table has no such section.
- R4: A byte-count word of zero ends the table. From then until `ack_i`, `s_ready_o` stays low, so no further stream word is consumed.
- R5: Byte lane i carries data bits 8i+7:8i. A word holding r remaining bytes, with r from 1 to 3, is written with enables for lanes 0..r-1 only, and all other payload words use 4'b1111. The word after the last payload word is the next byte-count header.
- R6: While `m_valid_o` is high and `m_ready_i` is low, the pending write's address, data and enables hold steady and no payload word is accepted. Every payload word is written exactly once.
- R7: `done_o` rises only after the last write has been accepted. `done_o` and `entry_o` then hold until `ack_i`, after which a new table is expected.
- R8: A destination address with bits 1:0 not zero sets `err_o`, writes nothing for that section, and stops stream consumption. `err_o` holds until `ack_i`.
- R9: After reset, `done_o`, `err_o` and `m_valid_o` are low. With `mode_i` = 0, `s_ready_o` is high so that the entry word can be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: explicit entry word, 1: header-only layout |
| s_data_i | input | 32 | Stream word |
| s_valid_i | input | 1 | Stream word valid |
| s_ready_o | output | 1 | Stream word accepted when high with valid |
| m_addr_o | output | 32 | Memory write byte address (word-aligned) |
| m_data_o | output | 32 | Memory write data |
| m_be_o | output | 4 | Memory write byte enables |
| m_valid_o | output | 1 | Memory write request |
| m_ready_i | input | 1 | Memory write accepted |
| done_o | output | 1 | Table complete, entry address valid |
| entry_o | output | 32 | Entry address |
| err_o | output | 1 | Load aborted on misaligned destination |
| ack_i | input | 1 | Clears done or error and restarts |

## Verification
The following are checked by assertions on every cycle:
- a stalled write holds steady, and no payload word is taken while it is stalled;
- write addresses stay aligned, and lane 0 is always enabled;
- done and error are never high together, and each holds until acknowledged;
- the stream is closed while done is high.

Some behaviour can only be shown by the bench's scenarios, with random memory back-pressure applied:
- the write addresses and data of each section, in stream order;
- the tail enables for every residue of the byte count;
- which entry address each layout reports;
- that a misaligned header produces no write at all.

// File: rtl/sl_pkg.sv
`timescale 1ns/1ps
package sl_pkg;
  typedef enum logic [2:0] {
    ST_ENTRY,
    ST_CNT,
    ST_ADDR,
    ST_DATA,
    ST_DONE,
    ST_ERR
  } sl_state_e;
endpackage

// File: rtl/sl_tail_be.sv
`timescale 1ns/1ps
module sl_tail_be #(
  parameter int BW = 4,
  parameter int CW = 32
) (
  input  logic [CW-1:0] rem_i,
  output logic [BW-1:0] be_o
);
  // lane i enabled when more than i bytes remain
  for (genvar i = 0; i < BW; i++) begin : g_lane
    assign be_o[i] = (rem_i > CW'(i));
  end
endmodule

// File: rtl/sl_wr_stage.sv
`timescale 1ns/1ps
module sl_wr_stage #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [AW-1:0] in_addr_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [BW-1:0] in_be_i,
  output logic [AW-1:0] m_addr_o,
  output logic [DW-1:0] m_data_o,
  output logic [BW-1:0] m_be_o,
  output logic          m_valid_o,
  input  logic          m_ready_i
);
  assign in_ready_o = !m_valid_o || m_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_o <= 1'b0;
      m_addr_o  <= '0;
      m_data_o  <= '0;
      m_be_o    <= '0;
    end else if (in_ready_o) begin
      m_valid_o <= in_valid_i;
      if (in_valid_i) begin
        m_addr_o <= in_addr_i;
        m_data_o <= in_data_i;
        m_be_o   <= in_be_i;
      end
    end
  end

  // R6
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_addr_o) &&
                                   $stable(m_data_o) && $stable(m_be_o)));
endmodule

// File: rtl/sect_loader.sv
`timescale 1ns/1ps
module sect_loader
  import sl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_valid_i,
  output logic          s_ready_o,
  output logic [AW-1:0] m_addr_o,
  output logic [DW-1:0] m_data_o,
  output logic [DW/8-1:0] m_be_o,
  output logic          m_valid_o,
  input  logic          m_ready_i,
  output logic          done_o,
  output logic [AW-1:0] entry_o,
  output logic          err_o,
  input  logic          ack_i
);
  localparam int BW  = DW / 8;
  localparam int OFS = $clog2(BW);

  sl_state_e     state_q;
  logic [DW-1:0] cnt_q;
  logic [AW-1:0] waddr_q, xentry_q, base_q, res_q;
  logic          wr_ready, accept;
  logic [BW-1:0] tail_be;

  always_comb begin
    unique case (state_q)
      ST_ENTRY:       s_ready_o = !mode_i;
      ST_CNT, ST_ADDR: s_ready_o = 1'b1;
      ST_DATA:        s_ready_o = wr_ready;
      default:        s_ready_o = 1'b0;
    endcase
  end
  assign accept = s_valid_i && s_ready_o;

  sl_tail_be #(.BW(BW), .CW(DW)) u_be (
    .rem_i (cnt_q),
    .be_o  (tail_be)
  );

  sl_wr_stage #(.AW(AW), .DW(DW), .BW(BW)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (state_q == ST_DATA && s_valid_i),
    .in_ready_o (wr_ready),
    .in_addr_i  (waddr_q),
    .in_data_i  (s_data_i),
    .in_be_i    (tail_be),
    .m_addr_o   (m_addr_o),
    .m_data_o   (m_data_o),
    .m_be_o     (m_be_o),
    .m_valid_o  (m_valid_o),
    .m_ready_i  (m_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ENTRY;
      cnt_q    <= '0;
      waddr_q  <= '0;
      xentry_q <= '0;
      base_q   <= '0;
      res_q    <= '0;
    end else begin
      unique case (state_q)
        ST_ENTRY: begin
          if (mode_i) state_q <= ST_CNT;
          else if (accept) begin
            xentry_q <= AW'(s_data_i);
            state_q  <= ST_CNT;
          end
        end
        ST_CNT: if (accept) begin
          if (s_data_i == '0) begin
            res_q   <= mode_i ? base_q : xentry_q;
            state_q <= ST_DONE;
          end else begin
            cnt_q   <= s_data_i;
            state_q <= ST_ADDR;
          end
        end
        ST_ADDR: if (accept) begin
          if (s_data_i[OFS-1:0] != '0) state_q <= ST_ERR;
          else begin
            waddr_q <= AW'(s_data_i);
            base_q  <= AW'(s_data_i);
            state_q <= ST_DATA;
          end
        end
        ST_DATA: if (accept) begin
          waddr_q <= waddr_q + AW'(BW);
          if (cnt_q <= DW'(BW)) begin
            cnt_q   <= '0;
            state_q <= ST_CNT;
          end else begin
            cnt_q <= cnt_q - DW'(BW);
          end
        end
        default: if (ack_i) begin
          base_q  <= '0;
          state_q <= ST_ENTRY;
        end
      endcase
    end
  end

  // done only once the final write has drained
  assign done_o  = (state_q == ST_DONE) && !m_valid_o;
  assign err_o   = (state_q == ST_ERR);
  assign entry_o = res_q;

  // R6
  no_take_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && m_valid_o && !m_ready_i) |-> !s_ready_o);
  // R1
  aligned_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> (m_addr_o[OFS-1:0] == '0));
  // R5
  lane0_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o |-> m_be_o[0]);
  // R4
  closed_when_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !s_ready_o);
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ack_i) |=> (done_o && $stable(entry_o)));
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !ack_i) |=> (err_o && !done_o));
endmodule

// File: tb/sect_loader_test.sv
`timescale 1ns/1ps
module sect_loader_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready_o;
  logic [31:0] m_addr_o, m_data_o, entry_o;
  logic [3:0]  m_be_o;
  logic        m_valid_o, done_o, err_o;
  logic        m_ready = 1'b1;
  logic        ack = 1'b0;

  sect_loader uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready_o),
    .m_addr_o(m_addr_o), .m_data_o(m_data_o), .m_be_o(m_be_o),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready),
    .done_o(done_o), .entry_o(entry_o), .err_o(err_o), .ack_i(ack)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic        stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] la [16];
  logic [31:0] ld [16];
  logic [3:0]  lb [16];
  int          wn = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // memory-side ready and write log; handshake completes at the next posedge
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = !stall_en || lfsr[0];
    #1;
    if (m_valid_o && m_ready && wn < 16) begin
      la[wn] = m_addr_o; ld[wn] = m_data_o; lb[wn] = m_be_o; wn++;
    end
  end

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      summary();
    end
  end

  task automatic send(input logic [31:0] w);
    logic r;
    @(negedge clk); s_valid = 1'b1; s_data = w;
    forever begin
      #1; r = s_ready_o;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    #1 s_valid = 1'b0;
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!done_o && !err_o);
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // byte count, words written, enables of last word
  localparam int NV = 8;
  localparam logic [31:0] V_CNT [NV] = '{1, 2, 3, 4, 5, 7, 8, 12};
  localparam int          V_NW  [NV] = '{1, 1, 1, 1, 2, 2, 2, 3};
  localparam logic [3:0]  V_BE  [NV] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111,
                                        4'b0001, 4'b0111, 4'b1111, 4'b1111};

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // R9 reset state
    chk(!done_o && !err_o && !m_valid_o, "R9 reset outputs", {done_o, err_o, m_valid_o}, 3'b000);
    chk(s_ready_o == 1'b1, "R9 ready for entry word", s_ready_o, 1);

    // explicit-entry layout under random back-pressure
    stall_en = 1'b1; wn = 0;
    send(32'hCAFE_0100);
    send(32'd8); send(32'h100); send(32'hA0A0_0001); send(32'hA0A0_0002);
    send(32'd6); send(32'h200); send(32'hB0B0_0003); send(32'hB0B0_0004);
    send(32'd0);
    @(negedge clk); s_valid = 1'b1; s_data = 32'hDEAD_BEEF;
    wait_end();
    chk(wn == 4, "R6 write count", wn, 4);
    chk({la[0], ld[0], lb[0]} == {32'h100, 32'hA0A0_0001, 4'hF}, "R1 write0", {la[0], ld[0]}, {32'h100, 32'hA0A0_0001});
    chk({la[1], ld[1], lb[1]} == {32'h104, 32'hA0A0_0002, 4'hF}, "R1 write1", {la[1], ld[1]}, {32'h104, 32'hA0A0_0002});
    chk({la[2], ld[2], lb[2]} == {32'h200, 32'hB0B0_0003, 4'hF}, "R1 write2", {la[2], ld[2]}, {32'h200, 32'hB0B0_0003});
    chk({la[3], ld[3], lb[3]} == {32'h204, 32'hB0B0_0004, 4'b0011}, "R5 write3 tail", lb[3], 4'b0011);
    chk(entry_o == 32'hCAFE_0100, "R2 entry word", entry_o, 32'hCAFE_0100);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!s_ready_o && done_o && entry_o == 32'hCAFE_0100, "R4 R7 closed and held",
          {s_ready_o, done_o, entry_o}, {1'b0, 1'b1, 32'hCAFE_0100});
    end
    chk(wn == 4, "R4 no write after end", wn, 4);
    @(negedge clk); s_valid = 1'b0;
    pulse_ack(); #1;
    chk(!done_o && s_ready_o, "R7 restart after ack", {done_o, s_ready_o}, 2'b01);

    // header-only layout: entry is base of last nonempty section
    mode = 1'b1; wn = 0;
    send(32'd4); send(32'h80); send(32'h1111_1111);
    send(32'd8); send(32'h300); send(32'h2222_2222); send(32'h3333_3333);
    send(32'd0);
    wait_end();
    chk(entry_o == 32'h300 && done_o, "R3 last base entry", entry_o, 32'h300);
    chk(wn == 3 && la[2] == 32'h304, "R1 header-only writes", {wn, la[2]}, {32'd3, 32'h304});
    pulse_ack();

    // tail-enable vectors, header-only layout
    for (int v = 0; v < NV; v++) begin
      wn = 0;
      send(V_CNT[v]); send(32'h40);
      for (int i = 0; i < V_NW[v]; i++) send({16'hC0DE, 8'(v), 8'(i)});
      send(32'd0);
      wait_end();
      chk(wn == V_NW[v], "R5 word count", wn, V_NW[v]);
      chk(wn > 0 && lb[V_NW[v]-1] == V_BE[v], "R5 tail enables", lb[V_NW[v]-1], V_BE[v]);
      chk(entry_o == 32'h40, "R3 entry vector", entry_o, 32'h40);
      pulse_ack();
    end

    // misaligned destination
    wn = 0;
    send(32'd4); send(32'h102);
    @(negedge clk); s_valid = 1'b1; s_data = 32'h5555_5555;
    repeat (3) @(negedge clk); #1;
    chk(err_o && !done_o && !s_ready_o, "R8 error raised", {err_o, done_o, s_ready_o}, 3'b100);
    chk(wn == 0, "R8 nothing written", wn, 0);
    s_valid = 1'b0;
    pulse_ack(); #1;
    chk(!err_o, "R8 cleared by ack", err_o, 0);

    // header-only layout, empty table
    wn = 0;
    send(32'd0);
    wait_end();
    chk(done_o && entry_o == 32'h0 && wn == 0, "R3 empty table", entry_o, 0);
    pulse_ack();

    // explicit-entry layout, empty table
    mode = 1'b0;
    @(negedge clk);
    send(32'h0000_8000); send(32'd0);
    wait_end();
    chk(entry_o == 32'h8000 && wn == 0, "R2 empty explicit", entry_o, 32'h8000);
    pulse_ack();

    summary();
  end
endmodule